// File: doc/BRIEF.md
# Idle-Frame Self-Refresh Entry Controller

This block decides when a display link may drop into panel self-refresh. Once armed by its enable bit, it counts consecutive frame boundaries in which nothing on screen changed. When that count reaches an effective idle threshold, it waits a fixed number of scan lines and then enters the active self-refresh state. In that state it asks the link layer to hold the main link either in standby or fully off.

The controller leaves self-refresh for any of these reasons:
- a frame change;
- an exit event that is not masked (memory update, hot-plug, low-power state);
- the enable bit being cleared;
- expiry of a maximum sleep window counted in frames.

On exit it raises a one-cycle wake request. That request carries the decoded durations of the two wake training patterns and tells the link layer which pattern set to use. After a wake with the enable still set, the controller re-arms and starts counting idle frames again. This gives a periodic exit and re-entry that refreshes the panel. Link training itself is done elsewhere.

Top module: `selfRefreshCtl`

## Requirements
- R1: After reset, `srState` is 0 (off), both link requests are 0, `wakeReq` is 0 and all wake duration outputs are 0.
- R2: In state 0, an edge sampling `enable`=1 moves `srState` to 1 (armed). In state 1 or 2, an edge sampling `enable`=0 moves it to 0.
- R3: The effective idle threshold is the larger of 6 and `idleThreshold`. In state 1, the edge sampling the Nth consecutive `vblank` strobe without a dirty condition moves `srState` to 2 (entry), where N is that effective threshold.
- R4: A dirty condition is a `frameChanged` strobe or an unmasked exit event. In state 1 it restarts the idle count from zero. In state 2 it returns `srState` to 1 with the idle count restarted. A dirty condition takes priority over a `vblank` or `lineStrobe` in the same cycle.
- R5: State 2 lasts until the 8th `lineStrobe`. The edge sampling that strobe moves `srState` to 3 (active); state 3 is entered only from state 2.
- R6: In state 3, `linkStandbyReq` equals `linkStandbySel` and `linkOffReq` equals its inverse. Outside state 3 both are 0, and they are never both 1.
- R7: In state 3, a dirty condition moves `srState` to 4 (wake) for exactly one cycle with `wakeReq`=1. State 1 follows if `enable` is 1.
- R8: An exit event whose mask bit is 1 (`maskMemUpdate`, `maskHotPlug`, `maskLowPower`) has no effect in any state.
- R9: The sleep window is the larger of 1 and the 5-bit `maxSleep`. In state 3, the edge sampling the `vblank` that completes the window moves `srState` to 4.
- R10: On entry to state 4, the wake durations are captured and held until the next wake:
  - `wakeTp1Us` and `wakeTp23Us` decode their 2-bit codes as 0→0, 1→100, 2→500 and 3→2500 (µs).
  - `wakeUseTp3` is `patternSetSel` (1 = patterns 1 and 3, 0 = patterns 1 and 2).
- R11: Clearing `enable` in state 3 moves `srState` to 4 with `wakeReq`=1. The next state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Arms the controller; clearing it forces exit |
| idleThreshold | input | 4 | Programmed idle frame count (floored at 6) |
| maxSleep | input | 5 | Frames allowed in active self-refresh (floored at 1) |
| linkStandbySel | input | 1 | 1 = main link to standby, 0 = main link off |
| tp1Code | input | 2 | Wake duration code, training pattern 1 |
| tp23Code | input | 2 | Wake duration code, second training pattern |
| patternSetSel | input | 1 | 1 = patterns 1 and 3, 0 = patterns 1 and 2 |
| frameChanged | input | 1 | Strobe: displayed content changed |
| vblank | input | 1 | Strobe: frame boundary |
| lineStrobe | input | 1 | Strobe: one scan line elapsed |
| memUpdateEvt | input | 1 | Exit event: memory update |
| hotPlugEvt | input | 1 | Exit event: hot-plug |
| lowPowerEvt | input | 1 | Exit event: low-power state |
| maskMemUpdate | input | 1 | Suppress memory-update exits |
| maskHotPlug | input | 1 | Suppress hot-plug exits |
| maskLowPower | input | 1 | Suppress low-power exits |
| srState | output | 3 | 0 off, 1 armed, 2 entry, 3 active, 4 wake |
| linkStandbyReq | output | 1 | Request main link standby |
| linkOffReq | output | 1 | Request main link off |
| wakeReq | output | 1 | One-cycle wake training request |
| wakeTp1Us | output | 12 | Pattern 1 wake duration in µs |
| wakeTp23Us | output | 12 | Second pattern wake duration in µs |
| wakeUseTp3 | output | 1 | Second wake pattern is pattern 3 |

## Verification
Every strobe and event is sampled at a rising edge, and `srState`, `wakeReq` and the captured durations change at that same edge. The link requests follow the new state combinationally.

The bench therefore drives inputs just after the falling edge and compares all outputs 1 ns after the next rising edge. A bench reference model is advanced once per cycle before that edge. Directed sequences count strobes exactly to the threshold, line and sleep boundaries, and check the cycle before and the cycle of each transition.

// File: rtl/selfRefreshPkg.sv
package selfRefreshPkg;

  localparam int WAKE_US_W = 12;

  typedef enum logic [2:0] {
    SR_OFF    = 3'd0,
    SR_ARMED  = 3'd1,
    SR_ENTRY  = 3'd2,
    SR_ACTIVE = 3'd3,
    SR_WAKE   = 3'd4
  } srState_e;

  // control -> datapath
  typedef struct packed {
    logic clrIdle;
    logic incIdle;
    logic clrLine;
    logic incLine;
    logic clrSleep;
    logic incSleep;
    logic latchWake;
  } srStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic idleLast;
    logic lineLast;
    logic sleepLast;
  } srFlags_t;

  function automatic logic [WAKE_US_W-1:0] wakeCodeToUs(input logic [1:0] code);
    case (code)
      2'd0:    return WAKE_US_W'(0);
      2'd1:    return WAKE_US_W'(100);
      2'd2:    return WAKE_US_W'(500);
      default: return WAKE_US_W'(2500);
    endcase
  endfunction

endpackage

// File: rtl/selfRefreshDatapath.sv
module selfRefreshDatapath
  import selfRefreshPkg::*;
#(
  parameter int IDLE_W      = 4,
  parameter int MIN_IDLE    = 6,
  parameter int SLEEP_W     = 5,
  parameter int ENTRY_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IDLE_W-1:0]    idleThreshold,
  input  logic [SLEEP_W-1:0]   maxSleep,
  input  logic [1:0]           tp1Code,
  input  logic [1:0]           tp23Code,
  input  logic                 patternSetSel,
  input  srStrobe_t            strobes,
  output srFlags_t             flags,
  output logic [WAKE_US_W-1:0] wakeTp1Us,
  output logic [WAKE_US_W-1:0] wakeTp23Us,
  output logic                 wakeUseTp3
);

  localparam int LINE_W = $clog2(ENTRY_LINES + 1);
  localparam logic [IDLE_W-1:0]  MIN_IDLE_V  = IDLE_W'(MIN_IDLE);
  localparam logic [LINE_W-1:0]  LINE_LAST_V = LINE_W'(ENTRY_LINES - 1);
  localparam logic [SLEEP_W-1:0] SLEEP_ONE   = SLEEP_W'(1);

  logic [IDLE_W-1:0]  idleCnt;
  logic [IDLE_W-1:0]  effIdle;
  logic [LINE_W-1:0]  lineCnt;
  logic [SLEEP_W-1:0] sleepCnt;
  logic [SLEEP_W-1:0] effSleep;

  // floor the programmed counts
  always_comb begin
    effIdle  = (idleThreshold < MIN_IDLE_V) ? MIN_IDLE_V : idleThreshold;
    effSleep = (maxSleep == '0) ? SLEEP_ONE : maxSleep;
  end

  // last-count flags: the next qualifying strobe completes the window
  always_comb begin
    flags.idleLast  = (idleCnt == (effIdle - IDLE_W'(1)));
    flags.lineLast  = (lineCnt == LINE_LAST_V);
    flags.sleepLast = (sleepCnt == (effSleep - SLEEP_ONE));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strobes.clrIdle) begin
      idleCnt <= '0;
    end else if (strobes.incIdle) begin
      idleCnt <= idleCnt + IDLE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt <= '0;
    end else if (strobes.clrLine) begin
      lineCnt <= '0;
    end else if (strobes.incLine) begin
      lineCnt <= lineCnt + LINE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sleepCnt <= '0;
    end else if (strobes.clrSleep) begin
      sleepCnt <= '0;
    end else if (strobes.incSleep) begin
      sleepCnt <= sleepCnt + SLEEP_ONE;
    end
  end

  // wake parameters captured at the moment of exit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakeTp1Us  <= '0;
      wakeTp23Us <= '0;
      wakeUseTp3 <= 1'b0;
    end else if (strobes.latchWake) begin
      wakeTp1Us  <= wakeCodeToUs(tp1Code);
      wakeTp23Us <= wakeCodeToUs(tp23Code);
      wakeUseTp3 <= patternSetSel;
    end
  end

endmodule

// File: rtl/selfRefreshControl.sv
module selfRefreshControl
  import selfRefreshPkg::*;
#(
  parameter int NUM_CAUSES = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  frameChanged,
  input  logic                  vblank,
  input  logic                  lineStrobe,
  input  logic [NUM_CAUSES-1:0] causeEvt,
  input  logic [NUM_CAUSES-1:0] causeMask,
  input  srFlags_t              flags,
  output srStrobe_t             strobes,
  output srState_e              state
);

  logic [NUM_CAUSES-1:0] liveCause;
  logic dirty;
  srState_e nextState;

  for (genvar g = 0; g < NUM_CAUSES; g++) begin : gCause
    assign liveCause[g] = causeEvt[g] & ~causeMask[g];
  end

  assign dirty = frameChanged | (|liveCause);

  always_comb begin
    nextState = state;
    strobes   = '0;
    case (state)
      SR_OFF: begin
        if (enable) begin
          nextState       = SR_ARMED;
          strobes.clrIdle = 1'b1;
        end
      end
      SR_ARMED: begin
        if (!enable) begin
          nextState = SR_OFF;
        end else if (dirty) begin
          strobes.clrIdle = 1'b1;
        end else if (vblank) begin
          if (flags.idleLast) begin
            nextState       = SR_ENTRY;
            strobes.clrLine = 1'b1;
            strobes.clrIdle = 1'b1;
          end else begin
            strobes.incIdle = 1'b1;
          end
        end
      end
      SR_ENTRY: begin
        if (!enable) begin
          nextState = SR_OFF;
        end else if (dirty) begin
          nextState       = SR_ARMED;
          strobes.clrIdle = 1'b1;
        end else if (lineStrobe) begin
          if (flags.lineLast) begin
            nextState        = SR_ACTIVE;
            strobes.clrSleep = 1'b1;
          end else begin
            strobes.incLine = 1'b1;
          end
        end
      end
      SR_ACTIVE: begin
        if (!enable || dirty || (vblank && flags.sleepLast)) begin
          nextState         = SR_WAKE;
          strobes.latchWake = 1'b1;
        end else if (vblank) begin
          strobes.incSleep = 1'b1;
        end
      end
      SR_WAKE: begin
        nextState       = enable ? SR_ARMED : SR_OFF;
        strobes.clrIdle = enable;
      end
      default: nextState = SR_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SR_OFF;
    else       state <= nextState;
  end

endmodule

// File: rtl/selfRefreshCtl.sv
module selfRefreshCtl
  import selfRefreshPkg::*;
#(
  parameter int IDLE_W      = 4,
  parameter int MIN_IDLE    = 6,
  parameter int SLEEP_W     = 5,
  parameter int ENTRY_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [IDLE_W-1:0]    idleThreshold,
  input  logic [SLEEP_W-1:0]   maxSleep,
  input  logic                 linkStandbySel,
  input  logic [1:0]           tp1Code,
  input  logic [1:0]           tp23Code,
  input  logic                 patternSetSel,
  input  logic                 frameChanged,
  input  logic                 vblank,
  input  logic                 lineStrobe,
  input  logic                 memUpdateEvt,
  input  logic                 hotPlugEvt,
  input  logic                 lowPowerEvt,
  input  logic                 maskMemUpdate,
  input  logic                 maskHotPlug,
  input  logic                 maskLowPower,
  output logic [2:0]           srState,
  output logic                 linkStandbyReq,
  output logic                 linkOffReq,
  output logic                 wakeReq,
  output logic [WAKE_US_W-1:0] wakeTp1Us,
  output logic [WAKE_US_W-1:0] wakeTp23Us,
  output logic                 wakeUseTp3
);

  localparam int NUM_CAUSES = 3;

  srStrobe_t strobes;
  srFlags_t  flags;
  srState_e  state;

  selfRefreshControl #(.NUM_CAUSES(NUM_CAUSES)) uCtl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .frameChanged (frameChanged),
    .vblank       (vblank),
    .lineStrobe   (lineStrobe),
    .causeEvt     ({lowPowerEvt, hotPlugEvt, memUpdateEvt}),
    .causeMask    ({maskLowPower, maskHotPlug, maskMemUpdate}),
    .flags        (flags),
    .strobes      (strobes),
    .state        (state)
  );

  selfRefreshDatapath #(
    .IDLE_W      (IDLE_W),
    .MIN_IDLE    (MIN_IDLE),
    .SLEEP_W     (SLEEP_W),
    .ENTRY_LINES (ENTRY_LINES)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .idleThreshold (idleThreshold),
    .maxSleep      (maxSleep),
    .tp1Code       (tp1Code),
    .tp23Code      (tp23Code),
    .patternSetSel (patternSetSel),
    .strobes       (strobes),
    .flags         (flags),
    .wakeTp1Us     (wakeTp1Us),
    .wakeTp23Us    (wakeTp23Us),
    .wakeUseTp3    (wakeUseTp3)
  );

  assign srState        = state;
  assign linkStandbyReq = (state == SR_ACTIVE) &  linkStandbySel;
  assign linkOffReq     = (state == SR_ACTIVE) & ~linkStandbySel;
  assign wakeReq        = (state == SR_WAKE);

endmodule

// File: rtl/selfRefreshChecker.sv
module selfRefreshChecker (
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic [2:0]  srState,
  input logic        linkStandbyReq,
  input logic        linkOffReq,
  input logic        wakeReq,
  input logic [11:0] wakeTp1Us,
  input logic [11:0] wakeTp23Us
);

  // R6
  link_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(linkStandbyReq && linkOffReq));

  // R7
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |=> !wakeReq);

  // R2
  arm_on_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srState == 3'd0 && enable) |=> (srState == 3'd1));

  // R11
  disable_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srState == 3'd3 && !enable) |=> (wakeReq && srState == 3'd4));

  // R11
  disable_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srState == 3'd4 && !enable) |=> (srState == 3'd0));

  // R5
  active_from_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(srState == 3'd3) |-> ($past(srState) == 3'd2));

  // R10
  wake_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> ((wakeTp1Us inside {12'd0, 12'd100, 12'd500, 12'd2500}) &&
                 (wakeTp23Us inside {12'd0, 12'd100, 12'd500, 12'd2500})));

endmodule

bind selfRefreshCtl selfRefreshChecker uChk (
  .clk            (clk),
  .rstN           (rstN),
  .enable         (enable),
  .srState        (srState),
  .linkStandbyReq (linkStandbyReq),
  .linkOffReq     (linkOffReq),
  .wakeReq        (wakeReq),
  .wakeTp1Us      (wakeTp1Us),
  .wakeTp23Us     (wakeTp23Us)
);

// File: tb/selfRefreshCtl_test.sv
module selfRefreshCtl_test;

  logic clk = 1'b0;
  logic rstN;
  logic enable, linkStandbySel, patternSetSel;
  logic [3:0] idleThreshold;
  logic [4:0] maxSleep;
  logic [1:0] tp1Code, tp23Code;
  logic frameChanged, vblank, lineStrobe;
  logic memUpdateEvt, hotPlugEvt, lowPowerEvt;
  logic maskMemUpdate, maskHotPlug, maskLowPower;
  logic [2:0]  srState;
  logic        linkStandbyReq, linkOffReq, wakeReq, wakeUseTp3;
  logic [11:0] wakeTp1Us, wakeTp23Us;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int mState, mIdle, mLine, mSleep, mTp1, mTp2;
  bit mUse3;

  always #10 clk = ~clk;

  selfRefreshCtl uut (.*);

  function automatic int decodeUs(input logic [1:0] c);
    case (c)
      2'd0: return 0;
      2'd1: return 100;
      2'd2: return 500;
      default: return 2500;
    endcase
  endfunction

  function automatic int effIdleOf(input logic [3:0] p);
    return (p < 6) ? 6 : int'(p);
  endfunction

  function automatic int effSleepOf(input logic [4:0] p);
    return (p == 0) ? 1 : int'(p);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic goWake();
    mState = 4;
    mTp1   = decodeUs(tp1Code);
    mTp2   = decodeUs(tp23Code);
    mUse3  = patternSetSel;
  endtask

  task automatic modelNext();
    bit dirty;
    dirty = frameChanged | (memUpdateEvt & ~maskMemUpdate) |
            (hotPlugEvt & ~maskHotPlug) | (lowPowerEvt & ~maskLowPower);
    case (mState)
      0: if (enable) begin mState = 1; mIdle = 0; end
      1: if (!enable) mState = 0;
         else if (dirty) mIdle = 0;
         else if (vblank) begin
           if (mIdle + 1 == effIdleOf(idleThreshold)) begin mState = 2; mLine = 0; mIdle = 0; end
           else mIdle++;
         end
      2: if (!enable) mState = 0;
         else if (dirty) begin mState = 1; mIdle = 0; end
         else if (lineStrobe) begin
           if (mLine + 1 == 8) begin mState = 3; mSleep = 0; end
           else mLine++;
         end
      3: if (!enable || dirty) goWake();
         else if (vblank) begin
           if (mSleep + 1 == effSleepOf(maxSleep)) goWake();
           else mSleep++;
         end
      default: if (enable) begin mState = 1; mIdle = 0; end else mState = 0;
    endcase
  endtask

  task automatic compareModel();
    check(int'(srState) == mState, "R4 model state", int'(srState), mState);
    check(linkStandbyReq == (mState == 3 && linkStandbySel) &&
          linkOffReq == (mState == 3 && !linkStandbySel),
          "R6 link requests", {linkStandbyReq, linkOffReq},
          {(mState == 3 && linkStandbySel), (mState == 3 && !linkStandbySel)});
    check(wakeReq == (mState == 4), "R7 wake request", wakeReq, (mState == 4));
    check(int'(wakeTp1Us) == mTp1 && int'(wakeTp23Us) == mTp2 && wakeUseTp3 == mUse3,
          "R10 wake durations", int'(wakeTp1Us), mTp1);
  endtask

  // one cycle: model advances on the inputs in place, compare after the edge
  task automatic tick();
    modelNext();
    @(posedge clk);
    #1;
    compareModel();
    @(negedge clk);
  endtask

  task automatic clearStrobes();
    frameChanged = 0; vblank = 0; lineStrobe = 0;
    memUpdateEvt = 0; hotPlugEvt = 0; lowPowerEvt = 0;
  endtask

  task automatic vblanks(input int n);
    for (int i = 0; i < n; i++) begin vblank = 1; tick(); vblank = 0; end
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) begin lineStrobe = 1; tick(); lineStrobe = 0; end
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rstN = 0; enable = 0; linkStandbySel = 1; patternSetSel = 0;
    idleThreshold = 4'd2; maxSleep = 5'd31; tp1Code = 0; tp23Code = 0;
    maskMemUpdate = 0; maskHotPlug = 0; maskLowPower = 0;
    clearStrobes();
    mState = 0; mIdle = 0; mLine = 0; mSleep = 0; mTp1 = 0; mTp2 = 0; mUse3 = 0;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(srState == 3'd0 && !linkStandbyReq && !linkOffReq && !wakeReq,
          "R1 reset outputs", srState, 0);
    check(wakeTp1Us == 0 && wakeTp23Us == 0 && !wakeUseTp3, "R1 reset durations",
          int'(wakeTp1Us), 0);
    rstN = 1;

    // R2 arm
    enable = 1; tick();
    check(srState == 3'd1, "R2 armed after enable", srState, 1);

    // R3 programmed 2 floors to 6
    for (int i = 0; i < 6; i++) begin
      vblank = 1; tick(); vblank = 0;
      if (i < 5) check(srState == 3'd1, "R3 still armed before 6th vblank", srState, 1);
    end
    check(srState == 3'd2, "R3 entry on 6th vblank", srState, 2);

    // R4 change during entry, then restart of count
    frameChanged = 1; tick(); frameChanged = 0;
    check(srState == 3'd1, "R4 change in entry back to armed", srState, 1);
    vblanks(3);
    frameChanged = 1; vblank = 1; tick(); clearStrobes();
    vblanks(5);
    check(srState == 3'd1, "R4 count restarted after change", srState, 1);
    vblanks(1);
    check(srState == 3'd2, "R4 entry after 6 clean vblanks", srState, 2);

    // R5 eight lines
    lines(7);
    check(srState == 3'd2, "R5 still entry after 7 lines", srState, 2);
    lines(1);
    check(srState == 3'd3, "R5 active after 8 lines", srState, 3);
    check(linkStandbyReq && !linkOffReq, "R6 standby selected", linkStandbyReq, 1);

    // R8 masked event ignored
    maskMemUpdate = 1; memUpdateEvt = 1; tick(); memUpdateEvt = 0;
    check(srState == 3'd3, "R8 masked event ignored", srState, 3);

    // R7 / R10 unmasked exit
    tp1Code = 2'd2; tp23Code = 2'd3; patternSetSel = 1;
    hotPlugEvt = 1; tick(); hotPlugEvt = 0;
    check(srState == 3'd4 && wakeReq, "R7 wake on unmasked event", srState, 4);
    check(wakeTp1Us == 12'd500 && wakeTp23Us == 12'd2500 && wakeUseTp3,
          "R10 captured durations", int'(wakeTp1Us), 500);
    tick();
    check(srState == 3'd1 && !wakeReq, "R7 rearmed after wake", srState, 1);

    // R3 threshold above the floor, R6 link off, R9 zero sleep floors to 1
    enable = 0; tick(); idleThreshold = 4'd9; maxSleep = 5'd0; linkStandbySel = 0;
    enable = 1; tick();
    vblanks(8);
    check(srState == 3'd1, "R3 armed after 8 of 9", srState, 1);
    vblanks(1);
    check(srState == 3'd2, "R3 entry on 9th vblank", srState, 2);
    lines(8);
    check(!linkStandbyReq && linkOffReq, "R6 link off selected", linkOffReq, 1);
    tp1Code = 2'd1; tp23Code = 2'd0; patternSetSel = 0;
    vblanks(1);
    check(srState == 3'd4, "R9 sleep window of 1", srState, 4);
    check(wakeTp1Us == 12'd100 && wakeTp23Us == 12'd0 && !wakeUseTp3,
          "R10 durations code 1/0", int'(wakeTp1Us), 100);
    tick();

    // R9 sleep window of 3
    enable = 0; tick(); maxSleep = 5'd3; enable = 1; tick();
    vblanks(9); lines(8);
    vblanks(2);
    check(srState == 3'd3, "R9 active after 2 of 3", srState, 3);
    vblanks(1);
    check(srState == 3'd4, "R9 wake on 3rd vblank", srState, 4);
    tick();

    // R11 disable while active
    maxSleep = 5'd31; vblanks(9); lines(8);
    check(srState == 3'd3, "R11 active before disable", srState, 3);
    enable = 0; tick();
    check(srState == 3'd4 && wakeReq, "R11 wake on disable", srState, 4);
    tick();
    check(srState == 3'd0, "R11 off after wake", srState, 0);

    // R2 disable from armed
    enable = 1; tick(); enable = 0; tick();
    check(srState == 3'd0, "R2 off after disable in armed", srState, 0);

    // random phase, config changes only while disabled
    maskMemUpdate = 0;
    for (int seg = 0; seg < 12; seg++) begin
      enable = 0; tick(); tick();
      idleThreshold = 4'($urandom_range(0, 15));
      maxSleep      = 5'($urandom_range(0, 6));
      tp1Code = 2'($urandom); tp23Code = 2'($urandom);
      patternSetSel = 1'($urandom); linkStandbySel = 1'($urandom);
      maskMemUpdate = 1'($urandom); maskHotPlug = 1'($urandom); maskLowPower = 1'($urandom);
      enable = 1;
      for (int c = 0; c < 300; c++) begin
        vblank       = ($urandom_range(0, 2) == 0);
        lineStrobe   = ($urandom_range(0, 1) == 0);
        frameChanged = ($urandom_range(0, 59) == 0);
        memUpdateEvt = ($urandom_range(0, 39) == 0);
        hotPlugEvt   = ($urandom_range(0, 39) == 0);
        lowPowerEvt  = ($urandom_range(0, 39) == 0);
        if ($urandom_range(0, 249) == 0) enable = 0;
        else if (!enable) enable = 1;
        tick();
        clearStrobes();
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule